// File: doc/BRIEF.md
# Control Endpoint OUT Handshake Controller

This block chooses the reply that a full-speed USB device gives at the end of an OUT or SETUP data stage on control endpoint 0. The packet engine pulses `pkt_done_i` when a data packet has been received. With that pulse it gives the token type, whether the CRC was good and whether the receive FIFO can take the packet. One cycle later the block drives a two-bit handshake code and a data-accept strobe. The packet engine then sends the handshake and commits or discards the FIFO write.

The block holds two status bits for the endpoint, halt and busy. Software changes them only through single-cycle strobes. The halt bit takes priority over every NAK source. Hardware clears it when a SETUP packet completes. A device-wide OUT-NAK input forces NAK while the endpoint is not halted. A snoop input makes the block accept data whatever its CRC result. The block also turns a two-bit code into the endpoint's maximum packet length in bytes.

Top module: `ep0_out_hs_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the halt bit, the busy bit, `hs_code_o` and `data_accept_o` all become 0.
- R2: A `halt_set_i` pulse sets the halt bit. While it is set, a good OUT packet gets STALL (`hs_code_o` = 2'b11) and `data_accept_o` stays low.
- R3: When halt is set, STALL is sent even if the busy bit, the global OUT-NAK, or both are also set.
- R4: A completed SETUP packet (`pkt_done_i` and `is_setup_i` both high) clears the halt bit at that edge. This clear wins over a `halt_set_i` in the same cycle.
- R5: When halt is clear and `glob_out_nak_i` is high, a good OUT packet gets NAK (2'b10), whatever the busy bit and FIFO space are.
- R6: A `busy_set_i` pulse sets the busy bit and a `busy_clr_i` pulse clears it; if both arrive together, the set wins. When halt and global OUT-NAK are clear and busy is set, a good OUT packet gets NAK.
- R7: When halt, global OUT-NAK and busy are all clear, a good OUT packet gets ACK (2'b01) with `data_accept_o` high if `fifo_room_i` is high. If `fifo_room_i` is low, it gets NAK with `data_accept_o` low.
- R8: When `snoop_i` is low, a packet with `crc_ok_i` low gets no handshake (2'b00) and `data_accept_o` stays low, for both OUT and SETUP.
- R9: When `snoop_i` is high, a packet with a bad CRC is handled exactly like one with a good CRC.
- R10: A good SETUP packet gets ACK with `data_accept_o` high when `fifo_room_i` is high, and no handshake otherwise, whatever the halt, busy and global OUT-NAK states.
- R11: `max_pkt_len_o` decodes `mps_code_i` combinationally as 00 = 64, 01 = 32, 10 = 16, 11 = 8 bytes.
- R12: `hs_code_o` and `data_accept_o` are registered. They show the decision in the cycle right after `pkt_done_i` and are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_set_i | input | 1 | Software strobe that sets the halt bit |
| busy_set_i | input | 1 | Software strobe that sets the busy (NAK) bit |
| busy_clr_i | input | 1 | Software strobe that clears the busy bit |
| glob_out_nak_i | input | 1 | Device-wide OUT-NAK control |
| snoop_i | input | 1 | Accept data without regard to CRC |
| mps_code_i | input | 2 | Maximum packet length code |
| pkt_done_i | input | 1 | One-cycle pulse: a data packet has been received |
| is_setup_i | input | 1 | Token of the finished packet was SETUP (else OUT) |
| crc_ok_i | input | 1 | Received CRC was correct |
| fifo_room_i | input | 1 | Receive FIFO can hold the packet |
| hs_code_o | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| data_accept_o | output | 1 | Commit the received data to the FIFO |
| halt_o | output | 1 | Current halt bit |
| busy_o | output | 1 | Current busy bit |
| max_pkt_len_o | output | 7 | Maximum packet length in bytes |

## Verification
Directed sequences put one NAK source at a time next to a halted endpoint, then all of them together. A STALL that wins only over the busy bit is therefore told apart from one that wins over the global OUT-NAK as well. SETUP packets arrive while halt is set, both with and without a same-cycle halt strobe, which exposes the wrong priority between the hardware clear and the software set. Bad-CRC packets are sent with snoop off and on, and with the FIFO full and not full, to separate the CRC gate from the space check. A long stretch of random strobes and packets, with a reset in the middle, is then checked cycle by cycle against a behavioural model.

// File: rtl/ep0o_pkg.sv
// Shared types for the endpoint-0 OUT handshake controller.
package ep0o_pkg;
    // Handshake code as the packet engine expects it
    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;
endpackage

// File: rtl/ep0o_status.sv
// Halt and busy status bits of endpoint 0.
// Assumes: strobes are single-cycle; setup_done_i is high for one cycle
// when a SETUP packet completes.
module ep0o_status (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_set_i,
    input  logic busy_set_i,
    input  logic busy_clr_i,
    input  logic setup_done_i,
    output logic halt_q_o,
    output logic busy_q_o
);
    logic halt_q;
    logic busy_q;

    // Halt bit: the hardware clear on SETUP wins over the software set
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (setup_done_i)
            halt_q <= 1'b0;
        else if (halt_set_i)
            halt_q <= 1'b1;
    end

    // Busy bit: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (busy_set_i)
            busy_q <= 1'b1;
        else if (busy_clr_i)
            busy_q <= 1'b0;
    end

    assign halt_q_o = halt_q;
    assign busy_q_o = busy_q;

    // R4
    setup_clears_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done_i |=> !halt_q);
    // R6
    busy_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_set_i |=> busy_q);
endmodule

// File: rtl/ep0o_decide.sv
// Combinational handshake choice for one finished packet.
// Assumes: the inputs are sampled only in the cycle where a packet completes.
module ep0o_decide
    import ep0o_pkg::*;
(
    input  logic is_setup_i,
    input  logic crc_ok_i,
    input  logic snoop_i,
    input  logic fifo_room_i,
    input  logic halt_i,
    input  logic busy_i,
    input  logic glob_nak_i,
    output hs_e  hs_o,
    output logic accept_o
);
    logic data_good;

    // Data counts as good when its CRC passed or snoop skips the check
    assign data_good = crc_ok_i | snoop_i;

    // Priority: CRC gate, SETUP, halt, global NAK, busy, FIFO space
    always_comb begin
        hs_o     = HS_NONE;
        accept_o = 1'b0;
        if (!data_good) begin
            hs_o = HS_NONE;
        end else if (is_setup_i) begin
            hs_o     = fifo_room_i ? HS_ACK : HS_NONE;
            accept_o = fifo_room_i;
        end else if (halt_i) begin
            hs_o = HS_STALL;
        end else if (glob_nak_i || busy_i) begin
            hs_o = HS_NAK;
        end else if (fifo_room_i) begin
            hs_o     = HS_ACK;
            accept_o = 1'b1;
        end else begin
            hs_o = HS_NAK;
        end
    end
endmodule

// File: rtl/ep0o_len_decode.sv
// Turns the packet-length code into a byte count: the largest size shifted
// right by the code. Assumes MAX_BYTES is a power of two.
module ep0o_len_decode #(
    parameter int CODE_W    = 2,
    parameter int MAX_BYTES = 64,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [LEN_W-1:0]  len_o
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BYTES);

    // Each code step halves the packet length
    always_comb begin
        len_o = MAX_LEN >> code_i;
    end
endmodule

// File: rtl/ep0_out_hs_ctrl.sv
// Top of the endpoint-0 OUT handshake controller. It registers the handshake
// choice one cycle after a packet completes and keeps the status bits.
// Assumes: pkt_done_i is a one-cycle pulse with its qualifiers valid.
module ep0_out_hs_ctrl
    import ep0o_pkg::*;
#(
    parameter int CODE_W    = 2,
    parameter int MAX_BYTES = 64,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_set_i,
    input  logic              busy_set_i,
    input  logic              busy_clr_i,
    input  logic              glob_out_nak_i,
    input  logic              snoop_i,
    input  logic [CODE_W-1:0] mps_code_i,
    input  logic              pkt_done_i,
    input  logic              is_setup_i,
    input  logic              crc_ok_i,
    input  logic              fifo_room_i,
    output logic [1:0]        hs_code_o,
    output logic              data_accept_o,
    output logic              halt_o,
    output logic              busy_o,
    output logic [LEN_W-1:0]  max_pkt_len_o
);
    logic halt_q, busy_q;
    hs_e  hs_next, hs_q;
    logic acc_next, acc_q;

    ep0o_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_set_i   (halt_set_i),
        .busy_set_i   (busy_set_i),
        .busy_clr_i   (busy_clr_i),
        .setup_done_i (pkt_done_i & is_setup_i),
        .halt_q_o     (halt_q),
        .busy_q_o     (busy_q)
    );

    ep0o_decide u_decide (
        .is_setup_i  (is_setup_i),
        .crc_ok_i    (crc_ok_i),
        .snoop_i     (snoop_i),
        .fifo_room_i (fifo_room_i),
        .halt_i      (halt_q),
        .busy_i      (busy_q),
        .glob_nak_i  (glob_out_nak_i),
        .hs_o        (hs_next),
        .accept_o    (acc_next)
    );

    ep0o_len_decode #(.CODE_W(CODE_W), .MAX_BYTES(MAX_BYTES)) u_len (
        .code_i (mps_code_i),
        .len_o  (max_pkt_len_o)
    );

    // Hold the decision for one cycle after the packet; idle otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !pkt_done_i) begin
            hs_q  <= HS_NONE;
            acc_q <= 1'b0;
        end else begin
            hs_q  <= hs_next;
            acc_q <= acc_next;
        end
    end

    assign hs_code_o     = hs_q;
    assign data_accept_o = acc_q;
    assign halt_o        = halt_q;
    assign busy_o        = busy_q;

    // R12
    hs_only_after_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code_o != HS_NONE) |-> $past(pkt_done_i));
    // R3
    stall_beats_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done_i && !is_setup_i && halt_o && (crc_ok_i || snoop_i))
        |=> (hs_code_o == HS_STALL));
    // R8
    bad_crc_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done_i && !crc_ok_i && !snoop_i)
        |=> (hs_code_o == HS_NONE && !data_accept_o));
    // R7
    accept_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_accept_o |-> (hs_code_o == HS_ACK));
endmodule

// File: tb/tb_ep0_out_hs_ctrl.sv
`timescale 1ns/1ps
module tb_ep0_out_hs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_set = 0, busy_set = 0, busy_clr = 0;
    logic       gnak = 0, snoop = 0;
    logic [1:0] mps = 2'b00;
    logic       pkt_done = 0, is_setup = 0, crc_ok = 0, room = 0;
    logic [1:0] hs_code;
    logic       accept, halt, busy;
    logic [6:0] max_len;

    always #2.5 clk = ~clk;

    ep0_out_hs_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .halt_set_i(halt_set), .busy_set_i(busy_set), .busy_clr_i(busy_clr),
        .glob_out_nak_i(gnak), .snoop_i(snoop), .mps_code_i(mps),
        .pkt_done_i(pkt_done), .is_setup_i(is_setup), .crc_ok_i(crc_ok),
        .fifo_room_i(room),
        .hs_code_o(hs_code), .data_accept_o(accept), .halt_o(halt),
        .busy_o(busy), .max_pkt_len_o(max_len)
    );

    // Behavioural reference model
    int     n_checks = 0, n_fail = 0;
    bit     started = 0;
    logic   m_halt = 0, m_busy = 0, m_acc = 0;
    logic [1:0] m_code = 0;
    string  t_hs = "R1", t_halt = "R1", t_busy = "R1";

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_halt = 0; m_busy = 0; m_code = 0; m_acc = 0;
            t_hs = "R1"; t_halt = "R1"; t_busy = "R1";
        end else begin
            m_code = 2'b00; m_acc = 0; t_hs = "R12";
            if (pkt_done) begin
                if (!(crc_ok || snoop)) begin
                    t_hs = "R8";
                end else if (is_setup) begin
                    t_hs = "R10";
                    if (room) begin m_code = 2'b01; m_acc = 1; end
                end else if (m_halt) begin
                    m_code = 2'b11; t_hs = (m_busy || gnak) ? "R3" : "R2";
                end else if (gnak) begin
                    m_code = 2'b10; t_hs = "R5";
                end else if (m_busy) begin
                    m_code = 2'b10; t_hs = "R6";
                end else begin
                    t_hs = crc_ok ? "R7" : "R9";
                    if (room) begin m_code = 2'b01; m_acc = 1; end
                    else m_code = 2'b10;
                end
            end
            if (pkt_done && is_setup) begin m_halt = 0; t_halt = "R4"; end
            else if (halt_set)        begin m_halt = 1; t_halt = "R2"; end
            if (busy_set)             begin m_busy = 1; t_busy = "R6"; end
            else if (busy_clr)        begin m_busy = 0; t_busy = "R6"; end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare every output on the falling edge
    always @(negedge clk) begin
        if (started) begin
            int exp_len;
            exp_len = (mps == 2'b00) ? 64 : (mps == 2'b01) ? 32 : (mps == 2'b10) ? 16 : 8;
            chk(hs_code === m_code, t_hs, "hs_code", hs_code, m_code);
            chk(accept === m_acc, t_hs, "data_accept", accept, m_acc);
            chk(halt === m_halt, t_halt, "halt", halt, m_halt);
            chk(busy === m_busy, t_busy, "busy", busy, m_busy);
            chk(max_len === 7'(exp_len), "R11", "max_pkt_len", max_len, exp_len);
        end
    end

    // One cycle of stimulus, applied just after a rising edge
    task automatic cyc(input logic hs, input logic bs, input logic bc,
                       input logic pd, input logic su, input logic crc,
                       input logic rm);
        @(posedge clk); #1;
        halt_set = hs; busy_set = bs; busy_clr = bc;
        pkt_done = pd; is_setup = su; crc_ok = crc; room = rm;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog
    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;                              // R1 reset state observed
        idle();
        cyc(0, 0, 0, 1, 0, 1, 1); idle();          // R7 ACK
        cyc(0, 0, 0, 1, 0, 1, 0); idle();          // R7 NAK, FIFO full
        cyc(0, 0, 0, 1, 0, 0, 1); idle();          // R8 bad CRC
        cyc(0, 0, 0, 1, 1, 0, 1); idle();          // R8 bad CRC SETUP
        snoop = 1;
        cyc(0, 0, 0, 1, 0, 0, 1); idle();          // R9 snoop ACK
        cyc(0, 0, 0, 1, 0, 0, 0); idle();          // R9 snoop NAK
        snoop = 0;
        cyc(0, 1, 0, 0, 0, 0, 0);                  // R6 set busy
        cyc(0, 0, 0, 1, 0, 1, 1); idle();          // R6 NAK
        cyc(0, 1, 1, 0, 0, 0, 0); idle();          // R6 set beats clear
        cyc(0, 0, 1, 0, 0, 0, 0);                  // R6 clear
        gnak = 1;
        cyc(0, 0, 0, 1, 0, 1, 1); idle();          // R5 global NAK
        gnak = 0;
        cyc(1, 0, 0, 0, 0, 0, 0);                  // R2 halt
        cyc(0, 0, 0, 1, 0, 1, 1); idle();          // R2 STALL
        cyc(0, 1, 0, 0, 0, 0, 0); gnak = 1;
        cyc(0, 0, 0, 1, 0, 1, 1); idle();          // R3 STALL over both
        cyc(0, 0, 0, 1, 1, 1, 1); idle();          // R10 SETUP ACK, R4 clears
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, 1, 1, 0); idle();          // R4 clear beats set; R10 no room
        gnak = 0;
        cyc(0, 0, 1, 0, 0, 0, 0);
        for (int c = 0; c < 4; c++) begin          // R11 all codes
            mps = 2'(c); idle();
        end
        for (int i = 0; i < 3000; i++) begin       // random phase
            if (i == 1500) begin @(posedge clk); #1 rst_n = 0; end
            if (i == 1503) rst_n = 1;
            gnak = ($urandom % 5) == 0;
            snoop = ($urandom % 6) == 0;
            mps = 2'($urandom);
            cyc(($urandom % 8) == 0, ($urandom % 7) == 0, ($urandom % 7) == 0,
                ($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 5) != 0,
                ($urandom % 3) != 0);
        end
        idle(); idle();
        @(negedge clk); #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule